// File: doc/BRIEF.md
# Soft Reset Controller with PHY Clock Activity Timeout

This block holds one small host-visible control word of a network controller and sequences a software-requested reset. When the host writes a 1 to the request bit, the block watches the PHY receive and transmit clocks. It toggles a flop in each PHY clock domain, carries the toggle into the system clock through a synchronizer, and looks for edges. When both clocks have shown activity, it drives the reset outputs for the MAC register group and the system register group for a fixed number of cycles. It also pulses a clear for the transmit and receive error flags. If either clock stays idle for the whole window, no reset is issued. The request is dropped and a sticky timeout flag is raised.

The word also carries a strap bit and an enable bit. The strap bit is the level of the management data pin, captured once after hard reset. The enable bit chooses the external MII port when set and the internal PHY when clear. Host writes are refused until the host has made at least one read after a hard reset, after a completed soft reset, or after a power-save exit pulse.

Control word layout: bit 0 = reset request / busy, bit 1 = timeout flag, bit 2 = external port enable, bit 3 = strap.

Top module: `soft_reset_ctl`

## Requirements
- R1: Once the hard reset is released and the strap has been captured, the control word reads 4'b1000 when the strap was 1 and 4'b0000 when it was 0. `mac_rst`, `sys_rst`, `err_clr` and `ext_mii_sel` are all low.
- R2: Bit 3 holds `strap_in` as sampled on the first clock after the hard reset is released. Later changes of `strap_in` and completed soft resets leave it unchanged.
- R3: After a hard reset, every host write leaves the word unchanged until one host read has been made. Writes take effect from the cycle after that read.
- R4: Bit 2 is read/write, resets to 0, and drives `ext_mii_sel` (1 = external MII port).
- R5: A permitted write with bit 0 set starts the operation, and bit 0 reads 1 from the next cycle until the operation ends. A write with bit 0 clear does not start it.
- R6: Once both PHY clocks have shown an edge, `mac_rst` and `sys_rst` rise together and stay high for exactly RST_CYC cycles. `err_clr` is high for the first of those cycles only.
- R7: Bit 0 still reads 1 in the first cycle after the reset outputs fall, and reads 0 in the cycle after that.
- R8: If either PHY clock shows no edge, the request is abandoned exactly TIMEOUT_CYC cycles after the write edge. At that point bit 0 becomes 0 and bit 1 becomes 1, and `mac_rst`/`sys_rst` never assert.
- R9: Bit 1 is sticky. A later timeout leaves it at 1, and only a completed soft reset clears it.
- R10: A completed soft reset clears bit 2 and re-arms the write block of R3.
- R11: A pulse on `pwr_save_exit` re-arms the write block of R3 and leaves the stored bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset |
| strap_in | input | 1 | Management data pin level, captured after hard reset |
| pwr_save_exit | input | 1 | One-cycle pulse on return from a power-saving state |
| reg_wr | input | 1 | Host write strobe for the control word |
| reg_rd | input | 1 | Host read strobe for the control word |
| reg_wdata | input | 4 | Host write data |
| reg_rdata | output | 4 | Control word read value |
| phy_rx_clk | input | 1 | PHY receive clock |
| phy_tx_clk | input | 1 | PHY transmit clock |
| mac_rst | output | 1 | Reset to the MAC register group |
| sys_rst | output | 1 | Reset to the system register group |
| err_clr | output | 1 | One-cycle clear of the transmit/receive error flags |
| ext_mii_sel | output | 1 | External MII port select |

## Verification
A sequencer stuck in its wait state shows at the ports as bit 0 held at 1 and the timeout flag set late or not at all, visible exactly TIMEOUT_CYC cycles after the request. A pulse counter that is off by one shows as a reset width that differs from RST_CYC, which the checker catches on the falling edge. A write gate in the wrong state shows on the very next cycle: bit 2 and `ext_mii_sel` either follow a write that should have been refused, or ignore one that should have been taken. A lost or stale activity flag shows either as a reset issued with one clock stopped or as a spurious timeout with both clocks running.

// File: rtl/srst_pkg.sv
package srst_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_WAIT   = 2'd1,
    SQ_PULSE  = 2'd2,
    SQ_FINISH = 2'd3
  } seq_state_t;

  localparam int BIT_BUSY  = 0;
  localparam int BIT_TMO   = 1;
  localparam int BIT_EXT   = 2;
  localparam int BIT_STRAP = 3;
  localparam int WORD_W    = 4;

  function automatic logic window_spent(input int unsigned elapsed, input int unsigned limit);
    return (elapsed + 1) >= limit;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic strap, input logic ext,
                                                  input logic tmo, input logic busy);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BIT_STRAP] = strap;
    w[BIT_EXT]   = ext;
    w[BIT_TMO]   = tmo;
    w[BIT_BUSY]  = busy;
    return w;
  endfunction

endpackage

// File: rtl/clk_activity_mon.sv
module clk_activity_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phy_clk,
  output logic edge_seen
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic             tog;
  logic [CHAIN-1:0] chain;

  always_ff @(posedge phy_clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN-2:0], tog};
  end

  assign edge_seen = chain[CHAIN-1] ^ chain[CHAIN-2];
endmodule

// File: rtl/srst_sequencer.sv
module srst_sequencer
  import srst_pkg::*;
#(
  parameter int TIMEOUT_CYC = 256,
  parameter int RST_CYC     = 8,
  parameter int NUM_CLK     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [NUM_CLK-1:0] activity,
  output logic               busy,
  output logic               pulse_on,
  output logic               first_pulse,
  output logic               start_evt,
  output logic               timeout_evt,
  output logic               done_evt
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam int CNT_W = $clog2(RST_CYC + 1);

  seq_state_t         state;
  logic [TMR_W-1:0]   timer;
  logic [CNT_W-1:0]   pcnt;
  logic [NUM_CLK-1:0] seen;
  logic               all_seen;

  assign all_seen    = &seen;
  assign start_evt   = (state == SQ_IDLE) && req;
  assign timeout_evt = (state == SQ_WAIT) && !all_seen &&
                       window_spent(32'(timer), TIMEOUT_CYC);
  assign done_evt    = (state == SQ_FINISH);
  assign busy        = (state != SQ_IDLE);
  assign pulse_on    = (state == SQ_PULSE);
  assign first_pulse = pulse_on && (pcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      timer <= '0;
      pcnt  <= '0;
      seen  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (req) begin
            state <= SQ_WAIT;
            timer <= '0;
            seen  <= '0;
          end
        end
        SQ_WAIT: begin
          seen <= seen | activity;
          if (all_seen) begin
            state <= SQ_PULSE;
            pcnt  <= '0;
          end else if (timeout_evt) begin
            state <= SQ_IDLE;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        SQ_PULSE: begin
          if (32'(pcnt) == RST_CYC - 1) state <= SQ_FINISH;
          else                          pcnt  <= pcnt + 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srst_csr.sv
module srst_csr
  import srst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_in,
  input  logic              pwr_save_exit,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              busy,
  input  logic              clr_sys,
  input  logic              timeout_evt,
  input  logic              done_evt,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              ext_en,
  output logic              req,
  output logic              wr_blocked,
  output logic              strap_locked
);
  logic strap_q;
  logic tmo_q;
  logic read_seen;
  logic wr_ok;

  assign wr_ok      = reg_wr && read_seen;
  assign wr_blocked = reg_wr && !read_seen;
  assign req        = wr_ok && reg_wdata[BIT_BUSY];
  assign reg_rdata  = pack_word(strap_q, ext_en, tmo_q, busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q      <= 1'b0;
      strap_locked <= 1'b0;
    end else if (!strap_locked) begin
      strap_q      <= strap_in;
      strap_locked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      read_seen <= 1'b0;
    else if (clr_sys || pwr_save_exit) read_seen <= 1'b0;
    else if (reg_rd)                 read_seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ext_en <= 1'b0;
    else if (clr_sys) ext_en <= 1'b0;
    else if (wr_ok)  ext_en <= reg_wdata[BIT_EXT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tmo_q <= 1'b0;
    else if (timeout_evt) tmo_q <= 1'b1;
    else if (done_evt)   tmo_q <= 1'b0;
  end
endmodule

// File: rtl/soft_reset_ctl.sv
module soft_reset_ctl
  import srst_pkg::*;
#(
  parameter int TIMEOUT_CYC = 256,
  parameter int RST_CYC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       hard_rst_n,
  input  logic       strap_in,
  input  logic       pwr_save_exit,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_wdata,
  output logic [3:0] reg_rdata,
  input  logic       phy_rx_clk,
  input  logic       phy_tx_clk,
  output logic       mac_rst,
  output logic       sys_rst,
  output logic       err_clr,
  output logic       ext_mii_sel
);
  localparam int NUM_CLK = 2;

  logic [NUM_CLK-1:0] phy_clks;
  logic [NUM_CLK-1:0] activity;
  logic busy, pulse_on, first_pulse, req;
  logic start_evt, timeout_evt, done_evt, wr_blocked, strap_locked, ext_en;

  assign phy_clks = {phy_tx_clk, phy_rx_clk};

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_mon
    clk_activity_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk      (clk),
      .rst_n    (hard_rst_n),
      .phy_clk  (phy_clks[g]),
      .edge_seen(activity[g])
    );
  end

  srst_sequencer #(
    .TIMEOUT_CYC(TIMEOUT_CYC), .RST_CYC(RST_CYC), .NUM_CLK(NUM_CLK)
  ) u_seq (
    .clk        (clk),
    .rst_n      (hard_rst_n),
    .req        (req),
    .activity   (activity),
    .busy       (busy),
    .pulse_on   (pulse_on),
    .first_pulse(first_pulse),
    .start_evt  (start_evt),
    .timeout_evt(timeout_evt),
    .done_evt   (done_evt)
  );

  srst_csr u_csr (
    .clk          (clk),
    .rst_n        (hard_rst_n),
    .strap_in     (strap_in),
    .pwr_save_exit(pwr_save_exit),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_wdata    (reg_wdata),
    .busy         (busy),
    .clr_sys      (pulse_on),
    .timeout_evt  (timeout_evt),
    .done_evt     (done_evt),
    .reg_rdata    (reg_rdata),
    .ext_en       (ext_en),
    .req          (req),
    .wr_blocked   (wr_blocked),
    .strap_locked (strap_locked)
  );

  assign mac_rst     = pulse_on;
  assign sys_rst     = pulse_on;
  assign err_clr     = first_pulse;
  assign ext_mii_sel = ext_en;
endmodule

// File: rtl/soft_reset_ctl_chk.sv
module soft_reset_ctl_chk #(
  parameter int RST_CYC = 8
) (
  input logic       clk,
  input logic       hard_rst_n,
  input logic [3:0] reg_rdata,
  input logic       mac_rst,
  input logic       sys_rst,
  input logic       err_clr,
  input logic       ext_mii_sel,
  input logic       start_evt,
  input logic       timeout_evt,
  input logic       wr_blocked,
  input logic       strap_locked
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n)  run_len <= 0;
    else if (mac_rst) run_len <= run_len + 1;
    else              run_len <= 0;
  end

  AST_RST_PAIRED: assert property (@(posedge clk) disable iff (!hard_rst_n)
    mac_rst == sys_rst); // R6
  AST_ERR_CLR_SINGLE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    err_clr |=> !err_clr); // R6
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $fell(mac_rst) |-> run_len == RST_CYC); // R6
  AST_BUSY_IN_RST: assert property (@(posedge clk) disable iff (!hard_rst_n)
    mac_rst |-> reg_rdata[0]); // R5
  AST_BUSY_LATE_CLEAR: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $fell(mac_rst) |-> reg_rdata[0] ##1 !reg_rdata[0]); // R7
  AST_TIMEOUT_NO_RST: assert property (@(posedge clk) disable iff (!hard_rst_n)
    timeout_evt |=> !mac_rst && reg_rdata[1] && !reg_rdata[0]); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!hard_rst_n)
    start_evt |=> reg_rdata[0]); // R5
  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!hard_rst_n)
    strap_locked |=> $stable(reg_rdata[3])); // R2
  AST_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (wr_blocked && !mac_rst) |=> $stable(ext_mii_sel)); // R3
endmodule

bind soft_reset_ctl soft_reset_ctl_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk         (clk),
  .hard_rst_n  (hard_rst_n),
  .reg_rdata   (reg_rdata),
  .mac_rst     (mac_rst),
  .sys_rst     (sys_rst),
  .err_clr     (err_clr),
  .ext_mii_sel (ext_mii_sel),
  .start_evt   (start_evt),
  .timeout_evt (timeout_evt),
  .wr_blocked  (wr_blocked),
  .strap_locked(strap_locked)
);

// File: tb/soft_reset_ctl_tb.sv
module soft_reset_ctl_tb;
  localparam int TMO = 40;
  localparam int RST = 5;
  localparam int NV  = 9;
  // {op[1:0], wdata[3:0], expected word[3:0]}; op 0 read, 1 write, 2 power-save exit
  localparam logic [9:0] VEC [NV] = '{
    {2'd1, 4'h4, 4'h8},   // R3 write before first read refused
    {2'd0, 4'h0, 4'h8},   // R3 read opens gate
    {2'd1, 4'h4, 4'hC},   // R4 set external enable
    {2'd1, 4'h0, 4'h8},   // R4 clear it
    {2'd1, 4'h4, 4'hC},   // R4 set again
    {2'd2, 4'h0, 4'hC},   // R11 exit keeps bits
    {2'd1, 4'h0, 4'hC},   // R11 write refused
    {2'd0, 4'h0, 4'hC},   // R11 read reopens
    {2'd1, 4'h0, 4'h8}    // R4 write accepted again
  };

  logic clk = 0, hard_rst_n = 0, strap_in = 1, pwr_save_exit = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_wdata = 0, reg_rdata;
  logic phy_rx_clk = 0, phy_tx_clk = 0, rx_run = 1, tx_run = 1;
  logic mac_rst, sys_rst, err_clr, ext_mii_sel;
  int n_chk = 0, n_bad = 0;
  logic saw_rst = 0;
  logic finished = 0;

  always #10 clk = ~clk;
  always #20 if (rx_run) phy_rx_clk = ~phy_rx_clk;
  always #18 if (tx_run) phy_tx_clk = ~phy_tx_clk;
  always @(posedge clk) if (mac_rst) saw_rst <= 1'b1;

  soft_reset_ctl #(.TIMEOUT_CYC(TMO), .RST_CYC(RST)) u_dut (
    .clk(clk), .hard_rst_n(hard_rst_n), .strap_in(strap_in),
    .pwr_save_exit(pwr_save_exit), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phy_rx_clk(phy_rx_clk),
    .phy_tx_clk(phy_tx_clk), .mac_rst(mac_rst), .sys_rst(sys_rst),
    .err_clr(err_clr), .ext_mii_sel(ext_mii_sel));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // drive one host op for one edge, return after the following negedge
  task automatic host(input logic [1:0] op, input logic [3:0] d);
    @(negedge clk);
    reg_rd = (op == 2'd0); reg_wr = (op == 2'd1); pwr_save_exit = (op == 2'd2);
    reg_wdata = d;
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; pwr_save_exit = 0; reg_wdata = 0;
  endtask

  task automatic do_hard_reset(input logic s);
    @(negedge clk);
    hard_rst_n = 0; strap_in = s;
    repeat (3) @(negedge clk);
    hard_rst_n = 1;
    repeat (3) @(negedge clk);
    strap_in = ~s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int width;
    logic [3:0] w;
    do_hard_reset(1'b1);
    chk("R1 word", reg_rdata, 4'h8);
    chk("R1 resets", {mac_rst, sys_rst, err_clr, ext_mii_sel}, 4'h0);
    chk("R2 strap held after pin change", reg_rdata[3], 1'b1);

    for (int i = 0; i < NV; i++) begin
      host(VEC[i][9:8], VEC[i][7:4]);
      chk($sformatf("vec %0d word", i), reg_rdata, VEC[i][3:0]);
      chk($sformatf("vec %0d R4 ext_mii_sel", i), ext_mii_sel, VEC[i][2]);
    end

    // successful soft reset with external enable set in the same write
    host(2'd1, 4'h5);
    chk("R5 busy after request", reg_rdata[0], 1'b1);
    chk("R4 ext set with request", ext_mii_sel, 1'b1);
    for (int k = 0; k < 50 && !mac_rst; k++) @(negedge clk);
    chk("R6 mac_rst rose", mac_rst, 1'b1);
    chk("R6 sys_rst with mac_rst", sys_rst, 1'b1);
    chk("R6 err_clr first cycle", err_clr, 1'b1);
    width = 0;
    while (mac_rst && width < 100) begin
      width++;
      @(negedge clk);
      if (mac_rst) chk("R6 err_clr only first", err_clr, 1'b0);
    end
    chk("R6 pulse width", width, RST);
    chk("R7 bit0 still set after fall", reg_rdata[0], 1'b1);
    @(negedge clk);
    chk("R7 bit0 cleared next cycle", reg_rdata[0], 1'b0);
    chk("R10 ext cleared, strap kept", reg_rdata, 4'h8);
    host(2'd1, 4'h4);
    chk("R10 write refused after reset", reg_rdata, 4'h8);
    host(2'd0, 4'h0);
    host(2'd1, 4'h4);
    chk("R10 write accepted after read", reg_rdata, 4'hC);
    host(2'd1, 4'h0);

    // timeout with receive clock stopped
    rx_run = 0;
    repeat (10) @(negedge clk);
    saw_rst = 0;
    @(negedge clk); reg_wr = 1; reg_wdata = 4'h1;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;   // after write edge E0
    repeat (TMO - 1) @(negedge clk);             // after E0+TMO-1
    w = reg_rdata;
    chk("R8 still waiting one cycle before limit", w[1:0], 2'b01);
    @(negedge clk);
    w = reg_rdata;
    chk("R8 timeout at limit", w[1:0], 2'b10);
    chk("R8 no reset issued", saw_rst, 1'b0);

    // second timeout with transmit clock stopped keeps the flag
    rx_run = 1; tx_run = 0;
    repeat (10) @(negedge clk);
    host(2'd1, 4'h1);
    repeat (TMO + 3) @(negedge clk);
    w = reg_rdata;
    chk("R9 flag sticky over second timeout", w[1:0], 2'b10);
    chk("R8 no reset with tx idle", saw_rst, 1'b0);

    // a completed soft reset clears the flag
    tx_run = 1;
    repeat (4) @(negedge clk);
    host(2'd1, 4'h1);
    for (int k = 0; k < 100 && reg_rdata[0]; k++) @(negedge clk);
    chk("R9 flag cleared by completed reset", reg_rdata[1:0], 2'b00);

    // hard reset with strap low
    do_hard_reset(1'b0);
    chk("R1 word with strap low", reg_rdata, 4'h0);
    chk("R2 strap low captured", reg_rdata[3], 1'b0);
    host(2'd1, 4'h4);
    chk("R3 write refused after hard reset", ext_mii_sel, 1'b0);
    summary();
  end
endmodule